// File: doc/BRIEF.md
# Linear Flash Read Sequencer

This block gives a processor read-only, memory-mapped access to a serial flash. It keeps one 1024-byte line of flash contents. A read whose address falls inside the buffered window is answered in the same cycle from that line. Any other read stalls. The block then runs a fetch on a byte-wide transfer port. The fetch first sends a command header: instruction, three address bytes, an optional mode byte and some zero dummy bytes. It then clocks in 1024 data bytes, which refill the line, and the stalled read is served from the new contents.

The header fields come from a 32-bit linear configuration word held in the block. The word is written through a one-cycle write strobe and is visible on an output. The requested address is divided by the number of parallel flash buses, which is one or two. The bit above the 24-bit region address drives an upper-device select output while a fetch runs. The byte-wide port is a plain handshake. The block holds a byte on `xfr_tx` with `xfr_valid` high. The serial shifter raises `xfr_ready` for one cycle when the byte is done, and presents the byte it received on `xfr_rx` in that same cycle. The reset input is asserted asynchronously and is expected to be released synchronously by the clock domain's reset synchroniser.

Top module: `lfr_seq`

## Requirements
- R1: The configuration word `cfg_word` resets to 0x03A002EB and takes the value on `cfg_wr_data` in the cycle after a cycle with `cfg_wr_en` high.
- R2: A read hits when the line is valid and base <= A <= base + 1020. On a hit, `req_ready` is high in the same cycle as `req_valid`. `rsp_data` holds the line bytes at offsets A-base .. A-base+3, with the lowest offset in bits [7:0]. An address of base + 1021 or above misses.
- R3: `req_size` selects the access width: 0 means byte, 1 means halfword, 2 or 3 means word. Lanes beyond the selected width read as zero, and lane 0 always carries the byte at offset A-base.
- R4: A fetch sends its header in this order: the instruction from config bits [7:0], flash address bits [23:16], [15:8] and [7:0], then the mode byte from config bits [23:16] (only when config bit 25 is 1), then N zero bytes, where N is config bits [10:8]. `xfr_tx` holds steady while a byte waits for `xfr_ready`.
- R5: After the header, a fetch sends exactly 1024 zero bytes. The bytes received for these fill line offsets 0..1023 in order. The bytes received during the header are discarded.
- R6: The flash address is A when `dual_bus` is 0 and A/2 when it is 1. `upper_page` equals flash address bit 24 during a fetch and returns to its previous value (low) when the fetch ends.
- R7: After a fetch, the line base is the flash address times the bus count. With two buses and an odd A, the window starts at A-1, and an address below the base misses.
- R8: The line is invalid after reset, so the first read fetches. A configuration write invalidates the line, so the next read fetches again.
- R9: A configuration write during a fetch leaves the line invalid when that fetch ends. The still-pending read then starts a new fetch that uses the new configuration.
- R10: During a miss, `req_ready` stays low until the refill is complete, and `req_ready` is never high while a fetch is running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| cfg_wr_en | input | 1 | Write strobe for the configuration word |
| cfg_wr_data | input | 32 | New configuration word |
| cfg_word | output | 32 | Current configuration word |
| dual_bus | input | 1 | 1 selects two parallel flash buses |
| req_valid | input | 1 | Read request present |
| req_addr | input | AW (25) | Read byte address |
| req_size | input | 2 | Access width: 0 byte, 1 halfword, 2/3 word |
| req_ready | output | 1 | Read accepted; rsp_data valid this cycle |
| rsp_data | output | 32 | Read data, little-endian lanes |
| xfr_valid | output | 1 | A byte is offered to the shifter |
| xfr_tx | output | 8 | Byte to send |
| xfr_ready | input | 1 | Shifter finished the current byte |
| xfr_rx | input | 8 | Byte received for the current transfer |
| upper_page | output | 1 | Upper flash device select |

## Verification
The bench builds the block with its default parameters: a 25-bit request address, which makes the region bit directly reachable, and a 1024-byte line, so reads at offsets 1020 and 1021 probe the real window edge. The bench's flash responder answers every byte one cycle after it is offered. It returns a marker during the header and a position-dependent pattern during the data phase, so a discarded header byte or a misplaced data byte shows up in the returned words. Both bus counts are exercised, including an odd address with two buses, and so is a configuration write made in the middle of a data phase.

// File: rtl/lfr_pkg.sv
package lfr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HDR  = 2'd1,
    ST_DATA = 2'd2
  } lfr_state_e;

  localparam logic [31:0] CFG_RESET_VAL = 32'h03A0_02EB;
  localparam int INST_LSB    = 0;
  localparam int DUMMY_LSB   = 8;
  localparam int DUMMY_W     = 3;
  localparam int MODE_LSB    = 16;
  localparam int MODE_EN_BIT = 25;
  localparam int ADDR_BYTES  = 3;
  localparam int HDR_IW      = 4;
endpackage

// File: rtl/lfr_hdr.sv
module lfr_hdr
  import lfr_pkg::*;
(
  input  logic [7:0]              inst,
  input  logic [7:0]              mode,
  input  logic                    mode_en,
  input  logic [DUMMY_W-1:0]      dummy,
  input  logic [8*ADDR_BYTES-1:0] faddr,
  input  logic [HDR_IW-1:0]       idx,
  output logic [7:0]              hdr_byte,
  output logic [HDR_IW-1:0]       hdr_len
);
  always_comb begin
    hdr_len = HDR_IW'(1 + ADDR_BYTES) + HDR_IW'(mode_en) + HDR_IW'(dummy);
  end

  always_comb begin
    hdr_byte = 8'h00;
    if (idx == '0) begin
      hdr_byte = inst;
    end else if (idx <= HDR_IW'(ADDR_BYTES)) begin
      for (int b = 1; b <= ADDR_BYTES; b++) begin
        if (idx == HDR_IW'(b)) hdr_byte = faddr[8*(ADDR_BYTES-b) +: 8];
      end
    end else if (idx == HDR_IW'(ADDR_BYTES + 1) && mode_en) begin
      hdr_byte = mode;
    end
  end
endmodule

// File: rtl/lfr_line.sv
module lfr_line #(
  parameter int AW         = 25,
  parameter int LINE_BYTES = 1024
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [$clog2(LINE_BYTES)-1:0] wr_idx,
  input  logic [7:0]                    wr_byte,
  input  logic                          commit,
  input  logic                          commit_keep,
  input  logic [AW:0]                   commit_base,
  input  logic                          inval,
  input  logic [AW-1:0]                 rd_addr,
  input  logic [1:0]                    rd_size,
  output logic                          hit,
  output logic [31:0]                   rd_data,
  output logic                          line_valid
);
  localparam int OFF_W    = $clog2(LINE_BYTES);
  localparam int LAST_OFF = LINE_BYTES - 4;

  logic [7:0]  mem [LINE_BYTES];
  logic        valid_q, valid_d;
  logic [AW:0] base_q, base_d;
  logic [AW:0] rd_ext, diff;
  logic [OFF_W-1:0] off;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_byte;
  end

  always_comb begin
    valid_d = valid_q;
    base_d  = base_q;
    if (commit) begin
      valid_d = commit_keep;
      base_d  = commit_base;
    end
    if (inval) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      base_q  <= '0;
    end else begin
      valid_q <= valid_d;
      base_q  <= base_d;
    end
  end

  always_comb begin
    rd_ext = {1'b0, rd_addr};
    diff   = rd_ext - base_q;
    off    = diff[OFF_W-1:0];
    hit    = valid_q && (rd_ext >= base_q) && (diff <= (AW+1)'(LAST_OFF));
  end

  for (genvar k = 0; k < 4; k++) begin : g_lane
    logic lane_on;
    always_comb begin
      lane_on = (k == 0) || (k == 1 && rd_size != 2'd0) || (k >= 2 && rd_size[1]);
      rd_data[8*k +: 8] = lane_on ? mem[off + OFF_W'(k)] : 8'h00;
    end
  end

  assign line_valid = valid_q;

  AST_CFG_INVAL: assert property (@(posedge clk) disable iff (!rst_n)
    inval |=> !line_valid); // R8
endmodule

// File: rtl/lfr_ctrl.sv
module lfr_ctrl
  import lfr_pkg::*;
#(
  parameter int AW         = 25,
  parameter int LINE_BYTES = 1024
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  input  logic [AW-1:0]                 req_addr,
  input  logic                          dual_bus,
  input  logic                          line_hit,
  input  logic [HDR_IW-1:0]             hdr_len,
  input  logic                          cfg_wr_en,
  input  logic                          xfr_ready,
  output logic                          xfr_valid,
  output logic                          hdr_phase,
  output logic [HDR_IW-1:0]             hdr_idx,
  output logic [$clog2(LINE_BYTES)-1:0] data_idx,
  output logic                          store_en,
  output logic                          commit,
  output logic                          commit_keep,
  output logic [AW:0]                   commit_base,
  output logic [AW-2:0]                 flash_addr,
  output logic                          upper_page,
  output logic                          busy
);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam logic [OFF_W-1:0] LAST_IDX = OFF_W'(LINE_BYTES - 1);

  lfr_state_e       state_q, state_d;
  logic [HDR_IW-1:0] idx_q, idx_d;
  logic [OFF_W-1:0] cnt_q, cnt_d;
  logic [AW-1:0]    fa_q, fa_d, fa_n;
  logic             upper_q, upper_d, usave_q, usave_d;
  logic             stale_q, stale_d, dual_q, dual_d;

  always_comb begin
    fa_n = dual_bus ? {1'b0, req_addr[AW-1:1]} : req_addr;
  end

  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    cnt_d    = cnt_q;
    fa_d     = fa_q;
    upper_d  = upper_q;
    usave_d  = usave_q;
    dual_d   = dual_q;
    stale_d  = stale_q | (cfg_wr_en && state_q != ST_IDLE);
    store_en = 1'b0;
    commit   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid && !line_hit) begin
          state_d = ST_HDR;
          idx_d   = '0;
          fa_d    = fa_n;
          dual_d  = dual_bus;
          usave_d = upper_q;
          upper_d = fa_n[AW-1];
          stale_d = 1'b0;
        end
      end
      ST_HDR: begin
        if (xfr_ready) begin
          if (idx_q == hdr_len - HDR_IW'(1)) begin
            state_d = ST_DATA;
            cnt_d   = '0;
          end else begin
            idx_d = idx_q + HDR_IW'(1);
          end
        end
      end
      ST_DATA: begin
        if (xfr_ready) begin
          store_en = 1'b1;
          if (cnt_q == LAST_IDX) begin
            commit  = 1'b1;
            state_d = ST_IDLE;
            upper_d = usave_q;
          end else begin
            cnt_d = cnt_q + OFF_W'(1);
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      cnt_q   <= '0;
      fa_q    <= '0;
      upper_q <= 1'b0;
      usave_q <= 1'b0;
      stale_q <= 1'b0;
      dual_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      cnt_q   <= cnt_d;
      fa_q    <= fa_d;
      upper_q <= upper_d;
      usave_q <= usave_d;
      stale_q <= stale_d;
      dual_q  <= dual_d;
    end
  end

  assign xfr_valid   = (state_q != ST_IDLE);
  assign hdr_phase   = (state_q == ST_HDR);
  assign busy        = xfr_valid;
  assign hdr_idx     = idx_q;
  assign data_idx    = cnt_q;
  assign commit_keep = !stale_q;
  assign commit_base = dual_q ? {fa_q, 1'b0} : {1'b0, fa_q};
  assign flash_addr  = fa_q[AW-2:0];
  assign upper_page  = upper_q;

  AST_IDLE_UPPER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !upper_page); // R6
  AST_XFR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (xfr_valid && !xfr_ready) |=> xfr_valid); // R4
endmodule

// File: rtl/lfr_seq.sv
module lfr_seq
  import lfr_pkg::*;
#(
  parameter int AW         = 25,
  parameter int LINE_BYTES = 1024
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr_en,
  input  logic [31:0]   cfg_wr_data,
  output logic [31:0]   cfg_word,
  input  logic          dual_bus,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_size,
  output logic          req_ready,
  output logic [31:0]   rsp_data,
  output logic          xfr_valid,
  output logic [7:0]    xfr_tx,
  input  logic          xfr_ready,
  input  logic [7:0]    xfr_rx,
  output logic          upper_page
);
  localparam int OFF_W = $clog2(LINE_BYTES);

  logic [31:0]       cfg_q;
  logic              hit, line_valid, hdr_phase, store_en, commit, commit_keep, busy;
  logic [HDR_IW-1:0] hdr_idx, hdr_len;
  logic [OFF_W-1:0]  data_idx;
  logic [AW:0]       commit_base;
  logic [AW-2:0]     flash_addr;
  logic [7:0]        hdr_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cfg_q <= CFG_RESET_VAL;
    else if (cfg_wr_en) cfg_q <= cfg_wr_data;
  end
  assign cfg_word = cfg_q;

  lfr_ctrl #(.AW(AW), .LINE_BYTES(LINE_BYTES)) i_ctrl (
    .clk, .rst_n, .req_valid, .req_addr, .dual_bus,
    .line_hit(hit), .hdr_len, .cfg_wr_en, .xfr_ready,
    .xfr_valid, .hdr_phase, .hdr_idx, .data_idx, .store_en, .commit,
    .commit_keep, .commit_base, .flash_addr, .upper_page, .busy
  );

  lfr_hdr i_hdr (
    .inst(cfg_q[INST_LSB +: 8]), .mode(cfg_q[MODE_LSB +: 8]),
    .mode_en(cfg_q[MODE_EN_BIT]), .dummy(cfg_q[DUMMY_LSB +: DUMMY_W]),
    .faddr(flash_addr[8*ADDR_BYTES-1:0]), .idx(hdr_idx),
    .hdr_byte, .hdr_len
  );

  lfr_line #(.AW(AW), .LINE_BYTES(LINE_BYTES)) i_line (
    .clk, .rst_n, .wr_en(store_en), .wr_idx(data_idx), .wr_byte(xfr_rx),
    .commit, .commit_keep, .commit_base, .inval(cfg_wr_en),
    .rd_addr(req_addr), .rd_size(req_size), .hit, .rd_data(rsp_data),
    .line_valid
  );

  assign xfr_tx    = hdr_phase ? hdr_byte : 8'h00;
  assign req_ready = req_valid && hit && !busy;

  AST_READY_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!xfr_valid && line_valid)); // R10
  AST_TX_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (xfr_valid && !xfr_ready && !cfg_wr_en) |=> $stable(xfr_tx)); // R4
endmodule

// File: tb/test_lfr_seq.sv
module test_lfr_seq;
  localparam int AW = 25;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_wr_en;
  logic [31:0]   cfg_wr_data, cfg_word;
  logic          dual_bus, req_valid, req_ready;
  logic [AW-1:0] req_addr;
  logic [1:0]    req_size;
  logic [31:0]   rsp_data;
  logic          xfr_valid, xfr_ready, upper_page;
  logic [7:0]    xfr_tx, xfr_rx;

  always #10 clk = ~clk;

  lfr_seq #(.AW(AW)) i_lfr_seq (
    .clk, .rst_n, .cfg_wr_en, .cfg_wr_data, .cfg_word, .dual_bus,
    .req_valid, .req_addr, .req_size, .req_ready, .rsp_data,
    .xfr_valid, .xfr_tx, .xfr_ready, .xfr_rx, .upper_page
  );

  int total = 0;
  int bad = 0;
  int hl = 7;
  logic [7:0] seed = 8'h3C;

  // flash responder state (written only by the responder)
  logic [7:0] hdr_seen [12];
  int n = 0, fetches = 0, fetch_len = 0, bad_tx = 0, upper_cnt = 0;
  logic prev_v;

  function automatic logic [7:0] pat(input int k);
    return 8'(k * 5 + (k >> 8) * 3) ^ seed;
  endfunction

  function automatic logic [31:0] exp_word(input int off, input logic [1:0] sz);
    logic [31:0] w = '0;
    for (int k = 0; k < 4; k++) begin
      if (k == 0 || (k == 1 && sz != 2'd0) || (k >= 2 && sz[1])) w[8*k +: 8] = pat(off + k);
    end
    return w;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xfr_ready <= 1'b0;
      xfr_rx    <= 8'h00;
      prev_v    <= 1'b0;
      n = 0;
    end else begin
      if (xfr_valid && !prev_v) fetches++;
      if (!xfr_valid && prev_v) fetch_len = n;
      if (!xfr_valid) n = 0;
      if (xfr_valid && upper_page) upper_cnt++;
      if (xfr_valid && xfr_ready) begin
        if (n < 12) hdr_seen[n] = xfr_tx;
        if (n >= hl && xfr_tx != 8'h00) bad_tx++;
        n++;
      end
      xfr_ready <= xfr_valid && !xfr_ready;
      xfr_rx    <= (n < hl) ? 8'hEE : pat(n - hl);
      prev_v    <= xfr_valid;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic [1:0] sz,
                         output logic [31:0] d, output int w);
    @(negedge clk);
    req_addr = a; req_size = sz; req_valid = 1'b1; w = 0;
    #1;
    while (!req_ready) begin
      @(negedge clk); #1; w++;
    end
    d = rsp_data;
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic write_cfg(input logic [31:0] v);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_data = v;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic chk_hdr(input string req, input logic [7:0] e0, e1, e2, e3);
    chk(hdr_seen[0] == e0, req, 32'(hdr_seen[0]), 32'(e0));
    chk(hdr_seen[1] == e1, req, 32'(hdr_seen[1]), 32'(e1));
    chk(hdr_seen[2] == e2, req, 32'(hdr_seen[2]), 32'(e2));
    chk(hdr_seen[3] == e3, req, 32'(hdr_seen[3]), 32'(e3));
  endtask

  // hit vectors: {offset from base [11:2], size [1:0]}
  localparam logic [11:0] VEC [8] = '{
    {10'd0, 2'd2}, {10'd4, 2'd2}, {10'd1, 2'd2}, {10'd2, 2'd0},
    {10'd3, 2'd1}, {10'd1020, 2'd2}, {10'd511, 2'd1}, {10'd255, 2'd3}
  };

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int w, f0, u0, b0;
    logic [AW-1:0] a;
    rst_n = 1'b0; cfg_wr_en = 1'b0; cfg_wr_data = '0; dual_bus = 1'b0;
    req_valid = 1'b0; req_addr = '0; req_size = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(cfg_word == 32'h03A002EB, "R1 reset cfg", cfg_word, 32'h03A002EB);
    chk(!xfr_valid && !upper_page, "R8 idle after reset", {30'd0, xfr_valid, upper_page}, 32'd0);
    rst_n = 1'b1;

    // first read: miss, default header, upper device
    a = 25'h100_0200;
    f0 = fetches; u0 = upper_cnt; b0 = bad_tx;
    do_read(a, 2'd2, d, w);
    chk(w > 100, "R10 stall on miss", 32'(w), 32'd101);
    chk(fetches - f0 == 1, "R8 first read fetches", 32'(fetches - f0), 32'd1);
    chk(upper_cnt > u0, "R6 upper select during fetch", 32'(upper_cnt - u0), 32'd1);
    chk(upper_page == 1'b0, "R6 upper select restored", 32'(upper_page), 32'd0);
    chk_hdr("R4 default header", 8'hEB, 8'h00, 8'h02, 8'h00);
    chk(hdr_seen[4] == 8'hA0 && hdr_seen[5] == 8'h00 && hdr_seen[6] == 8'h00,
        "R4 mode and dummies", {8'd0, hdr_seen[4], hdr_seen[5], hdr_seen[6]}, 32'h00A00000);
    chk(fetch_len == 7 + 1024, "R5 byte count", 32'(fetch_len), 32'd1031);
    chk(bad_tx == b0, "R5 zero data bytes", 32'(bad_tx - b0), 32'd0);
    chk(d == exp_word(0, 2'd2), "R2 miss word", d, exp_word(0, 2'd2));

    // table of hits
    foreach (VEC[i]) begin
      do_read(a + AW'(VEC[i][11:2]), VEC[i][1:0], d, w);
      chk(w == 0, "R2 hit without stall", 32'(w), 32'd0);
      chk(d == exp_word(int'(VEC[i][11:2]), VEC[i][1:0]), "R3 R5 hit data", d,
          exp_word(int'(VEC[i][11:2]), VEC[i][1:0]));
    end

    // window edge: base+1021 misses
    f0 = fetches;
    do_read(a + AW'(1021), 2'd2, d, w);
    chk(fetches - f0 == 1, "R2 edge miss", 32'(fetches - f0), 32'd1);
    chk_hdr("R4 edge header", 8'hEB, 8'h00, 8'h05, 8'hFD);
    chk(d == exp_word(0, 2'd2), "R2 edge word", d, exp_word(0, 2'd2));

    // config write invalidates; no mode byte, one dummy
    write_cfg(32'h0000_010B);
    hl = 5;
    chk(cfg_word == 32'h0000010B, "R1 cfg write", cfg_word, 32'h0000010B);
    f0 = fetches;
    do_read(a + AW'(1021), 2'd2, d, w);
    chk(fetches - f0 == 1, "R8 refetch after cfg write", 32'(fetches - f0), 32'd1);
    chk_hdr("R4 new header", 8'h0B, 8'h00, 8'h05, 8'hFD);
    chk(hdr_seen[4] == 8'h00 && fetch_len == 5 + 1024, "R4 no mode byte",
        32'(fetch_len), 32'd1029);

    // two buses, odd address
    dual_bus = 1'b1; seed = 8'h91;
    do_read(25'h000_0203, 2'd2, d, w);
    chk_hdr("R6 halved address", 8'h0B, 8'h00, 8'h01, 8'h01);
    chk(d == exp_word(1, 2'd2), "R7 odd address offset", d, exp_word(1, 2'd2));
    do_read(25'h000_0202, 2'd2, d, w);
    chk(w == 0 && d == exp_word(0, 2'd2), "R7 base at A-1", d, exp_word(0, 2'd2));
    f0 = fetches;
    do_read(25'h000_0201, 2'd0, d, w);
    chk(fetches - f0 == 1, "R7 below base misses", 32'(fetches - f0), 32'd1);
    chk(d == exp_word(1, 2'd0), "R3 R7 byte after refetch", d, exp_word(1, 2'd0));

    // config write in the middle of a data phase
    dual_bus = 1'b0; seed = 8'h47;
    f0 = fetches;
    fork
      do_read(25'h000_8000, 2'd2, d, w);
      begin
        wait (n >= 40);
        write_cfg(32'h03A0_02EB);
        hl = 7;
      end
    join
    chk(fetches - f0 == 2, "R9 fetch discarded and rerun", 32'(fetches - f0), 32'd2);
    chk_hdr("R9 header of rerun", 8'hEB, 8'h00, 8'h80, 8'h00);
    chk(hdr_seen[4] == 8'hA0 && fetch_len == 1031, "R9 rerun uses new cfg",
        32'(fetch_len), 32'd1031);
    chk(d == exp_word(0, 2'd2), "R9 data", d, exp_word(0, 2'd2));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule